// File: doc/BRIEF.md
# Destination Route Table with Default Port

This block maps a 16-bit destination identifier to an output port index for a packet switch. Software programs it through three configuration registers. A selector register names the destination ID that is being configured. A port register stores the output port for that selected ID when written, and returns it when read. A default register holds the port used for every ID that has no programmed route.

The table holds 2048 entries, indexed by the low 11 bits of the ID. Each entry keeps a valid flag, the remaining upper ID bits as a tag, and the port. A lookup hits only when the entry is valid and its tag matches the upper bits of the request. Any other lookup returns the default port. A lookup request on the lookup port returns its port one clock later, marked by a one-cycle result-valid pulse. Back-to-back requests are accepted on every cycle.

Configuration accesses use a simple strobe interface. A read returns its data one clock after the strobe, marked by a read-valid pulse. A write produces no response.

Top module: `dest_route_table`

## Requirements
- R1: After reset, the selector and default registers read 0. Every lookup returns port 0. Reading the port register returns 0. The lookup-valid and read-valid outputs stay low while no request is made.
- R2: Writing offset 0x70 stores the low 16 bits of the write data as the selected ID. Reading 0x70 returns that ID zero-extended.
- R3: Writing offset 0x78 stores the low PORT_W bits of the write data as the default port. Reading 0x78 returns that value zero-extended, with the upper bits 0.
- R4: Writing offset 0x74 stores the low PORT_W bits as the route of the currently selected ID and marks the entry valid. A later read of 0x74 with the same selection returns that port.
- R5: Reading 0x74 while the selected ID has no matching valid entry returns the current default port.
- R6: A lookup request presented in one cycle sets lk_vld high in the next cycle only, with lk_port holding the programmed port of a configured ID. This also holds for requests on consecutive cycles and for the highest table index.
- R7: A lookup of an ID with no valid entry returns the default port in force when the request was made, including after the default has changed.
- R8: Two IDs that share the low 11 bits but differ in the upper bits do not alias. The unprogrammed one resolves to the default. Programming it replaces the entry, and the earlier ID then resolves to the default.
- R9: Each configuration read strobe produces cfg_rvalid in the next cycle only. A write strobe produces no cfg_rvalid.
- R10: Writes to unmapped or unaligned offsets (for example 0x71, 0x75, 0x79, 0x7C) change no register and no route. A read of an unmapped offset returns 0 with cfg_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_stb | input | 1 | Configuration access strobe, one cycle per access |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | CFG_AW | Byte offset of the register |
| cfg_wdata | input | CFG_DW | Write data |
| cfg_rdata | output | CFG_DW | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read response pulse, one cycle after a read strobe |
| lk_req | input | 1 | Lookup request |
| lk_id | input | ID_W | Destination ID to resolve |
| lk_vld | output | 1 | Lookup result pulse, one cycle after lk_req |
| lk_port | output | PORT_W | Resolved output port |

## Verification
Every result of this block is due exactly one clock after the request that causes it. This holds for lookup results, for reads of any register, and for the port-register read that goes through the table. A register write takes effect at the edge that samples it, so the next access already sees the new value. The bench drives each request at a falling edge and samples the response at the following falling edge, which is one rising edge later. When two lookups run back to back, each result is sampled one half-cycle after the edge that registered it. After a write, the bench samples once more at that point to confirm that no read response appears.

// File: rtl/rtab_pkg.sv
package rtab_pkg;
  // Register offsets; the block's function depends on these decodes.
  localparam logic [7:0] OFS_SEL  = 8'h70;
  localparam logic [7:0] OFS_PORT = 8'h74;
  localparam logic [7:0] OFS_DFLT = 8'h78;

  // Which source feeds the pending configuration read response.
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_SEL  = 2'd1,
    RD_DFLT = 2'd2,
    RD_PORT = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/rtab_cfg_regs.sv
module rtab_cfg_regs
  import rtab_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int PORT_W = 8,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [ID_W-1:0]   sel_id,
  output logic [PORT_W-1:0] dflt_port,
  output logic              port_wr,
  output logic              port_rd,
  output logic              rd_vld,
  output rd_kind_e          rd_kind,
  output logic [DW-1:0]     rd_data
);
  logic              wr_acc, rd_acc;
  logic              hit_sel, hit_port, hit_dflt;
  logic [ID_W-1:0]   sel_q, sel_d;
  logic [PORT_W-1:0] dflt_q, dflt_d;
  logic              sel_en, dflt_en;
  rd_kind_e          kind_q, kind_d;
  logic [DW-1:0]     data_q, data_d;
  logic              vld_q;

  assign wr_acc   = stb & we;
  assign rd_acc   = stb & ~we;
  assign hit_sel  = (addr == AW'(OFS_SEL));
  assign hit_port = (addr == AW'(OFS_PORT));
  assign hit_dflt = (addr == AW'(OFS_DFLT));

  assign sel_en  = wr_acc & hit_sel;
  assign dflt_en = wr_acc & hit_dflt;
  assign port_wr = wr_acc & hit_port;
  assign port_rd = rd_acc & hit_port;

  always_comb begin
    sel_d  = wdata[ID_W-1:0];
    dflt_d = wdata[PORT_W-1:0];
    kind_d = RD_NONE;
    data_d = '0;
    if (rd_acc) begin
      if (hit_sel) begin
        kind_d = RD_SEL;
        data_d = DW'(sel_q);
      end else if (hit_dflt) begin
        kind_d = RD_DFLT;
        data_d = DW'(dflt_q);
      end else if (hit_port) begin
        kind_d = RD_PORT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      dflt_q <= '0;
      kind_q <= RD_NONE;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (sel_en)  sel_q  <= sel_d;
      if (dflt_en) dflt_q <= dflt_d;
      kind_q <= kind_d;
      data_q <= data_d;
      vld_q  <= rd_acc;
    end
  end

  assign sel_id    = sel_q;
  assign dflt_port = dflt_q;
  assign rd_vld    = vld_q;
  assign rd_kind   = kind_q;
  assign rd_data   = data_q;

  // R2
  sel_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_en |=> sel_id == $past(wdata[ID_W-1:0]));

  // R3
  dflt_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dflt_en |=> dflt_port == $past(wdata[PORT_W-1:0]));

  // R9
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rd_vld);

  // R9
  wr_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && we) |=> !rd_vld);
endmodule

// File: rtl/rtab_store.sv
module rtab_store #(
  parameter int IDX_W  = 11,
  parameter int TAG_W  = 5,
  parameter int PORT_W = 8,
  parameter int NRD    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [IDX_W-1:0]  rd_idx  [NRD],
  output logic              rd_ok   [NRD],
  output logic [TAG_W-1:0]  rd_tag  [NRD],
  output logic [PORT_W-1:0] rd_port [NRD]
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [PORT_W-1:0] port_mem [DEPTH];

  always_comb begin
    vld_d = vld_q;
    vld_d[wr_idx] = 1'b1;
  end

  // Valid flags carry reset; tag and port storage need none.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      port_mem[wr_idx] <= wr_port;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_ok[r]   = vld_q[rd_idx[r]];
    assign rd_tag[r]  = tag_mem[rd_idx[r]];
    assign rd_port[r] = port_mem[rd_idx[r]];
  end

  // R4
  entry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/rtab_resolve.sv
module rtab_resolve #(
  parameter int TAG_W  = 5,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              ent_ok,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [PORT_W-1:0] ent_port,
  input  logic [PORT_W-1:0] dflt,
  output logic              res_vld,
  output logic [PORT_W-1:0] res_port
);
  logic              hit;
  logic [PORT_W-1:0] port_d, port_q;
  logic              vld_q;

  assign hit = ent_ok && (ent_tag == req_tag);

  always_comb begin
    port_d = hit ? ent_port : dflt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      port_q <= '0;
    end else begin
      vld_q <= req;
      if (req) port_q <= port_d;
    end
  end

  assign res_vld  = vld_q;
  assign res_port = port_q;

  // R6
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> res_vld);

  // R6
  res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !res_vld);

  // R7
  miss_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ent_ok) |=> res_port == $past(dflt));
endmodule

// File: rtl/dest_route_table.sv
module dest_route_table
  import rtab_pkg::*;
#(
  parameter int ID_W    = 16,
  parameter int ENTRIES = 2048,
  parameter int PORT_W  = 8,
  parameter int CFG_AW  = 8,
  parameter int CFG_DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_stb,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic              cfg_rvalid,
  input  logic              lk_req,
  input  logic [ID_W-1:0]   lk_id,
  output logic              lk_vld,
  output logic [PORT_W-1:0] lk_port
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ID_W - IDX_W;
  localparam int NRD   = 2;   // 0: lookup port, 1: port-register read

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [ID_W-1:0]   sel_id;
  logic [PORT_W-1:0] dflt_port;
  logic              port_wr, port_rd;
  logic              rd_vld;
  rd_kind_e          rd_kind;
  logic [CFG_DW-1:0] rd_data;

  rtab_cfg_regs #(
    .ID_W(ID_W), .PORT_W(PORT_W), .AW(CFG_AW), .DW(CFG_DW)
  ) regs_i (
    .clk(clk), .rst_n(rst_s),
    .stb(cfg_stb), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .sel_id(sel_id), .dflt_port(dflt_port),
    .port_wr(port_wr), .port_rd(port_rd),
    .rd_vld(rd_vld), .rd_kind(rd_kind), .rd_data(rd_data)
  );

  logic              req_v  [NRD];
  logic [ID_W-1:0]   id_v   [NRD];
  logic [IDX_W-1:0]  idx_v  [NRD];
  logic              ok_v   [NRD];
  logic [TAG_W-1:0]  tag_v  [NRD];
  logic [PORT_W-1:0] ent_v  [NRD];
  logic              rvld_v [NRD];
  logic [PORT_W-1:0] rport_v[NRD];

  assign req_v[0] = lk_req;
  assign id_v[0]  = lk_id;
  assign req_v[1] = port_rd;
  assign id_v[1]  = sel_id;

  rtab_store #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .PORT_W(PORT_W), .NRD(NRD)
  ) store_i (
    .clk(clk), .rst_n(rst_s),
    .wr_en(port_wr),
    .wr_idx(sel_id[IDX_W-1:0]),
    .wr_tag(sel_id[ID_W-1:IDX_W]),
    .wr_port(cfg_wdata[PORT_W-1:0]),
    .rd_idx(idx_v), .rd_ok(ok_v), .rd_tag(tag_v), .rd_port(ent_v)
  );

  for (genvar r = 0; r < NRD; r++) begin : g_res
    assign idx_v[r] = id_v[r][IDX_W-1:0];
    rtab_resolve #(.TAG_W(TAG_W), .PORT_W(PORT_W)) res_i (
      .clk(clk), .rst_n(rst_s),
      .req(req_v[r]), .req_tag(id_v[r][ID_W-1:IDX_W]),
      .ent_ok(ok_v[r]), .ent_tag(tag_v[r]), .ent_port(ent_v[r]),
      .dflt(dflt_port),
      .res_vld(rvld_v[r]), .res_port(rport_v[r])
    );
  end

  assign lk_vld     = rvld_v[0];
  assign lk_port    = rport_v[0];
  assign cfg_rvalid = rd_vld;
  assign cfg_rdata  = (rd_kind == RD_PORT) ? CFG_DW'(rport_v[1]) : rd_data;

  // R9
  port_rd_align_chk: assert property (@(posedge clk) disable iff (!rst_s)
    rvld_v[1] |-> (cfg_rvalid && rd_kind == RD_PORT));
endmodule

// File: tb/dest_route_table_tb_top.sv
`timescale 1ns/1ps
module dest_route_table_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_stb, cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        cfg_rvalid;
  logic        lk_req;
  logic [15:0] lk_id;
  logic        lk_vld;
  logic [7:0]  lk_port;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dest_route_table dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_stb(cfg_stb), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .lk_req(lk_req), .lk_id(lk_id), .lk_vld(lk_vld), .lk_port(lk_port)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_stb = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_stb = 0; cfg_we = 0;
  endtask

  task automatic cfg_rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_stb = 1; cfg_we = 0; cfg_addr = a;
    @(negedge clk);
    cfg_stb = 0;
    chk({req, " rvalid"}, 32'(cfg_rvalid), 32'd1);
    chk(req, cfg_rdata, exp);
  endtask

  task automatic look_chk(input string req, input logic [15:0] id, input logic [7:0] exp);
    @(negedge clk);
    lk_req = 1; lk_id = id;
    @(negedge clk);
    lk_req = 0;
    chk({req, " lk_vld"}, 32'(lk_vld), 32'd1);
    chk(req, 32'(lk_port), 32'(exp));
  endtask

  task automatic route(input logic [15:0] id, input logic [7:0] p);
    cfg_wr(8'h70, 32'(id));
    cfg_wr(8'h74, 32'(p));
  endtask

  task automatic t_reset;
    chk("R1 idle lk_vld", 32'(lk_vld), 0);
    chk("R1 idle rvalid", 32'(cfg_rvalid), 0);
    cfg_rd_chk("R1 sel reset", 8'h70, 0);
    cfg_rd_chk("R1 dflt reset", 8'h78, 0);
    cfg_rd_chk("R1 port reset", 8'h74, 0);
    look_chk("R1 lookup reset", 16'h1234, 8'h00);
  endtask

  task automatic t_select;
    cfg_wr(8'h70, 32'hABCD_1234);
    cfg_rd_chk("R2 sel readback", 8'h70, 32'h0000_1234);
  endtask

  task automatic t_program;
    cfg_wr(8'h70, 32'h0005);
    cfg_wr(8'h74, 32'hFFFF_FF03);
    chk("R9 no rvalid after write", 32'(cfg_rvalid), 0);
    cfg_rd_chk("R4 port readback", 8'h74, 32'h3);
    look_chk("R6 lookup hit", 16'h0005, 8'h03);
    route(16'h07FF, 8'h06);
    look_chk("R6 top index", 16'h07FF, 8'h06);
  endtask

  task automatic t_default;
    cfg_wr(8'h78, 32'hFFFF_FF09);
    cfg_rd_chk("R3 dflt readback", 8'h78, 32'h09);
    look_chk("R7 miss default", 16'h0100, 8'h09);
    cfg_wr(8'h70, 32'h0100);
    cfg_rd_chk("R5 port read unconfigured", 8'h74, 32'h09);
    look_chk("R6 hit unaffected by default", 16'h0005, 8'h03);
  endtask

  task automatic t_alias;
    look_chk("R8 alias miss", 16'h0805, 8'h09);
    route(16'h0805, 8'h04);
    look_chk("R8 alias programmed", 16'h0805, 8'h04);
    look_chk("R8 replaced id misses", 16'h0005, 8'h09);
  endtask

  task automatic t_pipeline;
    @(negedge clk);
    lk_req = 1; lk_id = 16'h07FF;
    @(negedge clk);
    lk_id = 16'h0100;
    chk("R6 b2b first vld", 32'(lk_vld), 1);
    chk("R6 b2b first port", 32'(lk_port), 6);
    @(negedge clk);
    lk_req = 0;
    chk("R6 b2b second vld", 32'(lk_vld), 1);
    chk("R6 b2b second port", 32'(lk_port), 9);
    @(negedge clk);
    chk("R6 vld drops", 32'(lk_vld), 0);
  endtask

  task automatic t_ignore;
    cfg_wr(8'h7C, 32'h55);
    cfg_wr(8'h71, 32'h0100);
    cfg_wr(8'h75, 32'h07);
    cfg_wr(8'h79, 32'h33);
    cfg_rd_chk("R10 sel kept", 8'h70, 32'h0805);
    cfg_rd_chk("R10 dflt kept", 8'h78, 32'h09);
    cfg_rd_chk("R10 route kept", 8'h74, 32'h04);
    cfg_rd_chk("R10 unmapped reads zero", 8'h7C, 32'h0);
    look_chk("R10 lookup kept", 16'h0805, 8'h04);
  endtask

  initial begin
    rst_n = 0; cfg_stb = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    lk_req = 0; lk_id = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_select();
    t_program();
    t_default();
    t_alias();
    t_pipeline();
    t_ignore();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule